// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits beside the receive path of one message channel and turns a stream of per-message arrival pulses into one interrupt per batch. Arrivals and transmit-link completions are gathered into a pending batch. The batch is reported as soon as its message count reaches a programmable limit, or once a programmable number of 100 µs timebase ticks has passed since the batch became non-empty, whichever happens first. On each report the block latches a 32-bit status word that holds a rolling 4-bit tag, the message count and a link-event flag. It then holds its interrupt level until software returns the next tag value.

Software controls the block through a small write port with four addresses: a bit-set address and a bit-clear address for the control bits, a limits address, and an acknowledge address. At start-up the path is held in reset. The expected sequence is: program the limits, release the path reset, write the first acknowledge, then set the interrupt enable. Events that arrive while a report waits for its acknowledge are carried into the next batch.

Top module: `rxirq_coalesce`

## Requirements
- R1: The status word holds the batch tag in bits [3:0], the message count in bits [10:4] and the link-event flag in bit 16. All other bits read zero. The word changes only when a batch is reported and is held until the next report.
- R2: A write to the limits address (reg_sel = 2) loads the count limit from bits [7:0] and the time limit from bits [15:8]. A batch is reported on the clock edge after its pending message count first reaches the count limit. A count limit of 0 reports any non-empty batch at once.
- R3: A non-empty batch is reported on the clock edge after the number of timebase ticks seen since it became non-empty reaches the time limit, even when fewer messages than the count limit are pending. A time limit of 0 reports on the first edge after the batch becomes non-empty.
- R4: After rst_n the count limit is 16 and the time limit is 10.
- R5: The irq output goes high on a report and stays high until the matching acknowledge is accepted. It is gated by control bit 18 (interrupt enable): while that bit is clear, irq is low, and the pending report appears on irq once the bit is set.
- R6: A write to the acknowledge address (reg_sel = 3) is accepted only while a report is outstanding or the block awaits its first acknowledge, and only when data bits [3:0] equal the current tag plus one, modulo 16 (15 is followed by 0). An accepted value becomes the tag of the next batch. Any other acknowledge is ignored.
- R7: Messages that arrive while an acknowledge is outstanding, or in the same cycle as a report, count toward the next batch and are not lost. A time limit that has run out when the acknowledge is accepted reports on the following edge.
- R8: The pending message count saturates at 127.
- R9: Control bit 17 (path reset) is set through the set address (reg_sel = 0) and cleared through the clear address (reg_sel = 1); the same applies to bit 18. While bit 17 is set, the pending count, the link flag, the timer and irq are cleared, events are ignored, and the block returns to waiting for an acknowledge with its tag unchanged. After rst_n bit 17 is set and bit 18 is clear.
- R10: A link-completion pulse sets the link flag of the current batch. A batch holding only a link event is reported through the time limit with a message count of 0.
- R11: After rst_n, irq is low, the status word is 0, the tag is 0 and the block waits for an acknowledge of value 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register address: 0 set bits, 1 clear bits, 2 limits, 3 acknowledge |
| reg_wdata | input | 32 | Register write data |
| msg_arrive | input | 1 | One-cycle pulse per received message |
| link_done | input | 1 | One-cycle pulse when a transmit link record is consumed |
| tick_100us | input | 1 | One-cycle timebase pulse every 100 µs |
| irq | output | 1 | Interrupt level |
| status_word | output | 32 | Status of the last reported batch |

## Verification
The bench targets the edges where coalescing logic tends to slip. A message arriving in the same cycle as a report must go into the next batch; a design that clears the count after sampling it would drop that message, and the follow-up batch would time out empty or report the wrong count. An acknowledge carrying the wrong tag must leave irq high; a design that re-arms on any acknowledge would lower it. Arrivals during path reset must not count, and the tag must survive the reset; a design that got either wrong would report a count of 2 instead of 1, or would reject the acknowledge that follows. Saturation at 127, a link-only batch, zero limits and the tag wrap from 15 to 0 each get their own case, since an off-by-one in any of them changes the reported count, the tick count or the tag.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

  localparam int unsigned TAG_W = 4;
  localparam int unsigned CNT_W = 7;

  // status word layout
  localparam int unsigned STAT_TAG_LSB  = 0;
  localparam int unsigned STAT_CNT_LSB  = 4;
  localparam int unsigned STAT_LINK_BIT = 16;

  // control bit positions
  localparam int unsigned CTL_RST_BIT = 17;
  localparam int unsigned CTL_IEN_BIT = 18;

  typedef enum logic [1:0] {
    REG_SET    = 2'd0,
    REG_CLR    = 2'd1,
    REG_LIMITS = 2'd2,
    REG_ACK    = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_WAIT_ACK = 1'b0,
    ST_ARMED    = 1'b1
  } rpt_state_e;

  function automatic logic [31:0] pack_status(input logic [TAG_W-1:0] tag,
                                              input logic [CNT_W-1:0] cnt,
                                              input logic             lnk);
    logic [31:0] s;
    s = '0;
    s[STAT_TAG_LSB +: TAG_W] = tag;
    s[STAT_CNT_LSB +: CNT_W] = cnt;
    s[STAT_LINK_BIT]         = lnk;
    return s;
  endfunction

endpackage

// File: rtl/rxirq_ctl_regs.sv
module rxirq_ctl_regs
  import rxirq_pkg::*;
#(
  parameter int unsigned LIM_W        = 8,
  parameter int unsigned DEF_CNT_LIM  = 16,
  parameter int unsigned DEF_TIME_LIM = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             ien_o,
  output logic             prst_o,
  output logic [LIM_W-1:0] cnt_lim_o,
  output logic [LIM_W-1:0] time_lim_o,
  output logic             ack_wr_o,
  output logic [TAG_W-1:0] ack_val_o
);

  localparam int unsigned TL_LSB = LIM_W;

  logic             ien_q, ien_d;
  logic             prst_q, prst_d;
  logic [LIM_W-1:0] cnt_lim_q, time_lim_q;
  logic             lim_en;
  logic             set_wr, clr_wr;
  logic             unused_wdata;

  assign set_wr = reg_we && (reg_sel == REG_SET);
  assign clr_wr = reg_we && (reg_sel == REG_CLR);
  assign lim_en = reg_we && (reg_sel == REG_LIMITS);

  // set has priority over clear only in the sense that they never coincide
  always_comb begin
    ien_d  = ien_q;
    prst_d = prst_q;
    if (set_wr) begin
      if (reg_wdata[CTL_IEN_BIT]) ien_d  = 1'b1;
      if (reg_wdata[CTL_RST_BIT]) prst_d = 1'b1;
    end else if (clr_wr) begin
      if (reg_wdata[CTL_IEN_BIT]) ien_d  = 1'b0;
      if (reg_wdata[CTL_RST_BIT]) prst_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      prst_q <= 1'b1;
    end else begin
      ien_q  <= ien_d;
      prst_q <= prst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lim_q  <= LIM_W'(DEF_CNT_LIM);
      time_lim_q <= LIM_W'(DEF_TIME_LIM);
    end else if (lim_en) begin
      cnt_lim_q  <= reg_wdata[LIM_W-1:0];
      time_lim_q <= reg_wdata[TL_LSB +: LIM_W];
    end
  end

  assign ien_o      = ien_q;
  assign prst_o     = prst_q;
  assign cnt_lim_o  = cnt_lim_q;
  assign time_lim_o = time_lim_q;
  assign ack_wr_o   = reg_we && (reg_sel == REG_ACK);
  assign ack_val_o  = reg_wdata[TAG_W-1:0];

  assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/rxirq_batch_acc.sv
module rxirq_batch_acc
  import rxirq_pkg::*;
#(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic             msg_i,
  input  logic             link_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             link_o,
  output logic [TMR_W-1:0] ticks_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             link_q, link_d;
  logic [TMR_W-1:0] ticks_q, ticks_d;
  logic             busy;

  assign busy = (cnt_q != '0) || link_q;

  always_comb begin
    cnt_d   = cnt_q;
    link_d  = link_q;
    ticks_d = ticks_q;
    if (hold_i) begin
      cnt_d   = '0;
      link_d  = 1'b0;
      ticks_d = '0;
    end else if (restart_i) begin
      // events in the report cycle open the next batch
      cnt_d   = msg_i ? CNT_W'(1) : '0;
      link_d  = link_i;
      ticks_d = '0;
    end else begin
      if (msg_i && (cnt_q != CNT_MAX)) cnt_d = cnt_q + CNT_W'(1);
      if (link_i) link_d = 1'b1;
      if (busy && tick_i && (ticks_q != TMR_MAX)) ticks_d = ticks_q + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      link_q  <= 1'b0;
      ticks_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      link_q  <= link_d;
      ticks_q <= ticks_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign link_o  = link_q;
  assign ticks_o = ticks_q;
  assign busy_o  = busy;

endmodule

// File: rtl/rxirq_report.sv
module rxirq_report
  import rxirq_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             link_i,
  input  logic [LIM_W-1:0] ticks_i,
  input  logic             busy_i,
  input  logic [LIM_W-1:0] cnt_lim_i,
  input  logic [LIM_W-1:0] time_lim_i,
  input  logic             ack_wr_i,
  input  logic [TAG_W-1:0] ack_val_i,
  output logic             flush_o,
  output logic             pend_o,
  output logic [31:0]      status_o,
  output logic [TAG_W-1:0] tag_o
);

  localparam int unsigned CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;

  rpt_state_e       state_q, state_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             pend_q, pend_d;
  logic [31:0]      status_q;
  logic             cnt_hit, time_hit, flush, ack_ok;

  assign cnt_hit  = (cnt_i != '0) && (CMP_W'(cnt_i) >= CMP_W'(cnt_lim_i));
  assign time_hit = busy_i && (ticks_i >= time_lim_i);
  assign flush    = (state_q == ST_ARMED) && !hold_i && (cnt_hit || time_hit);
  assign ack_ok   = ack_wr_i && (state_q == ST_WAIT_ACK) && !hold_i &&
                    (ack_val_i == (tag_q + TAG_W'(1)));

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    pend_d  = pend_q;
    if (hold_i) begin
      state_d = ST_WAIT_ACK;
      pend_d  = 1'b0;
    end else if (flush) begin
      state_d = ST_WAIT_ACK;
      pend_d  = 1'b1;
    end else if (ack_ok) begin
      state_d = ST_ARMED;
      pend_d  = 1'b0;
      tag_d   = ack_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_ACK;
      tag_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (flush) begin
      status_q <= pack_status(tag_q, cnt_i, link_i);
    end
  end

  assign flush_o  = flush;
  assign pend_o   = pend_q;
  assign status_o = status_q;
  assign tag_o    = tag_q;

endmodule

// File: rtl/rxirq_coalesce.sv
module rxirq_coalesce
  import rxirq_pkg::*;
#(
  parameter int unsigned LIM_W        = 8,
  parameter int unsigned DEF_CNT_LIM  = 16,
  parameter int unsigned DEF_TIME_LIM = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        msg_arrive,
  input  logic        link_done,
  input  logic        tick_100us,
  output logic        irq,
  output logic [31:0] status_word
);

  logic             ien_w, prst_w, ack_wr_w;
  logic [TAG_W-1:0] ack_val_w, tag_w;
  logic [LIM_W-1:0] cnt_lim_w, time_lim_w, ticks_w;
  logic [CNT_W-1:0] cnt_w;
  logic             link_w, busy_w, flush_w, rpt_pend_w;

  rxirq_ctl_regs #(
    .LIM_W       (LIM_W),
    .DEF_CNT_LIM (DEF_CNT_LIM),
    .DEF_TIME_LIM(DEF_TIME_LIM)
  ) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ien_o     (ien_w),
    .prst_o    (prst_w),
    .cnt_lim_o (cnt_lim_w),
    .time_lim_o(time_lim_w),
    .ack_wr_o  (ack_wr_w),
    .ack_val_o (ack_val_w)
  );

  rxirq_batch_acc #(
    .TMR_W(LIM_W)
  ) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (prst_w),
    .restart_i(flush_w),
    .msg_i    (msg_arrive),
    .link_i   (link_done),
    .tick_i   (tick_100us),
    .cnt_o    (cnt_w),
    .link_o   (link_w),
    .ticks_o  (ticks_w),
    .busy_o   (busy_w)
  );

  rxirq_report #(
    .LIM_W(LIM_W)
  ) rpt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (prst_w),
    .cnt_i     (cnt_w),
    .link_i    (link_w),
    .ticks_i   (ticks_w),
    .busy_i    (busy_w),
    .cnt_lim_i (cnt_lim_w),
    .time_lim_i(time_lim_w),
    .ack_wr_i  (ack_wr_w),
    .ack_val_i (ack_val_w),
    .flush_o   (flush_w),
    .pend_o    (rpt_pend_w),
    .status_o  (status_word),
    .tag_o     (tag_w)
  );

  assign irq = rpt_pend_w & ien_w;

endmodule

// File: rtl/rxirq_chk.sv
module rxirq_chk
  import rxirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic             prst,
  input logic             pend,
  input logic [TAG_W-1:0] tag,
  input logic             irq,
  input logic [31:0]      status_word
);

  // R5: irq only drops on a clear or acknowledge write, or under path reset
  a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !prst && !(reg_we && (reg_sel == REG_CLR || reg_sel == REG_ACK))) |=> irq);

  // R9: path reset drops irq by the next cycle
  a_r9_prst_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> !irq);

  // R1: unused status bits read zero
  a_r1_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[31:17] == '0) && (status_word[15:11] == '0));

  // R1: the status word only moves when a report is raised
  a_r1_status_on_report: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_word) |-> $rose(pend));

  // R6: the tag only changes on an acknowledge write
  a_r6_tag_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag) |-> $past(reg_we && (reg_sel == REG_ACK)));

  // R6: the tag advances by exactly one, modulo 16
  a_r6_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag) |-> (tag == TAG_W'($past(tag) + TAG_W'(1))));

endmodule

bind rxirq_coalesce rxirq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .prst       (prst_w),
  .pend       (rpt_pend_w),
  .tag        (tag_w),
  .irq        (irq),
  .status_word(status_word)
);

// File: tb/rxirq_coalesce_tb_top.sv
module rxirq_coalesce_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        msg_arrive, link_done, tick_100us;
  logic        irq;
  logic [31:0] status_word;

  always #10 clk = ~clk;

  rxirq_coalesce dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .msg_arrive (msg_arrive),
    .link_done  (link_done),
    .tick_100us (tick_100us),
    .irq        (irq),
    .status_word(status_word)
  );

  localparam logic [31:0] BIT_RST = 32'h0002_0000;
  localparam logic [31:0] BIT_IEN = 32'h0004_0000;

  // {cnt_lim[39:32], time_lim[31:24], nmsg[23:16], link[15], exp_cnt[14:8], exp_ticks[7:0]}
  localparam int NVEC = 9;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd4,   8'd3, 8'd4, 1'b0, 7'd4, 8'd0},
    {8'd4,   8'd3, 8'd2, 1'b0, 7'd2, 8'd3},
    {8'd1,   8'd5, 8'd1, 1'b0, 7'd1, 8'd0},
    {8'd8,   8'd0, 8'd1, 1'b0, 7'd1, 8'd0},
    {8'd10,  8'd2, 8'd0, 1'b1, 7'd0, 8'd2},
    {8'd3,   8'd4, 8'd3, 1'b1, 7'd3, 8'd0},
    {8'd255, 8'd1, 8'd5, 1'b0, 7'd5, 8'd1},
    {8'd6,   8'd7, 8'd5, 1'b1, 7'd5, 8'd7},
    {8'd0,   8'd9, 8'd1, 1'b0, 7'd1, 8'd0}
  };

  int         n_chk = 0;
  int         n_err = 0;
  logic [3:0] exp_tag;

  function automatic logic [31:0] exp_status(input logic [3:0] t, input int c, input bit l);
    logic [31:0] s;
    s = '0;
    s[3:0]  = t;
    s[10:4] = 7'(c);
    s[16]   = l;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic send(input int nmsg, input bit lnk);
    int n;
    n = (nmsg > 0) ? nmsg : (lnk ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      msg_arrive = (i < nmsg);
      link_done  = (i == 0) && lnk;
    end
    @(negedge clk);
    msg_arrive = 1'b0; link_done = 1'b0;
  endtask

  task automatic wait_flush(output int ticks, output bit seen);
    ticks = 0; seen = 1'b0;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
      tick_100us = 1'b1;
      @(negedge clk);
      tick_100us = 1'b0;
      ticks++;
    end
  endtask

  task automatic ack_ok(input string req);
    wr(2'd3, {28'd0, 4'(exp_tag + 4'd1)});
    exp_tag = exp_tag + 4'd1;
    chk(irq == 1'b0, req, "irq after ack", {31'd0, irq}, 32'd0);
  endtask

  task automatic check_report(input int exp_cnt, input bit exp_lnk,
                              input int exp_ticks, input string req);
    int  t;
    bit  seen;
    wait_flush(t, seen);
    chk(seen, req, "irq raised", {31'd0, seen}, 32'd1);
    chk(t == exp_ticks, req, "ticks to report", 32'(t), 32'(exp_ticks));
    chk(status_word == exp_status(exp_tag, exp_cnt, exp_lnk), req, "status word",
        status_word, exp_status(exp_tag, exp_cnt, exp_lnk));
  endtask

  task automatic run_batch(input int nmsg, input bit lnk, input int exp_cnt,
                           input int exp_ticks, input string req);
    send(nmsg, lnk);
    check_report(exp_cnt, lnk, exp_ticks, req);
    ack_ok(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    msg_arrive = 1'b0; link_done = 1'b0; tick_100us = 1'b0;
    exp_tag = 4'd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R11: reset state
    chk(irq == 1'b0, "R11", "irq after reset", {31'd0, irq}, 32'd0);
    chk(status_word == 32'd0, "R11", "status after reset", status_word, 32'd0);

    // R9: path reset is set after rst_n, these arrivals must be ignored
    send(3, 1'b0);
    wr(2'd1, BIT_RST);
    ack_ok("R11");
    wr(2'd0, BIT_IEN);

    // R4: default limits, R9: earlier arrivals not counted
    run_batch(1, 1'b0, 1, 10, "R4");
    run_batch(16, 1'b0, 16, 0, "R4");

    // R1 R2 R3 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd2, {16'd0, VEC[v][31:24], VEC[v][39:32]});
      run_batch(int'(VEC[v][23:16]), VEC[v][15], int'(VEC[v][14:8]),
                int'(VEC[v][7:0]), "R2 R3 R10");
    end

    // R6: wrong acknowledges are ignored
    wr(2'd2, {16'd0, 8'd5, 8'd1});
    send(1, 1'b0);
    check_report(1, 1'b0, 0, "R6");
    wr(2'd3, {28'd0, 4'(exp_tag + 4'd2)});
    idle(1);
    chk(irq == 1'b1, "R6", "irq after wrong ack", {31'd0, irq}, 32'd1);
    wr(2'd3, {28'd0, exp_tag});
    idle(1);
    chk(irq == 1'b1, "R6", "irq after stale ack", {31'd0, irq}, 32'd1);
    ack_ok("R6");

    // R5: enable gating
    wr(2'd1, BIT_IEN);
    send(1, 1'b0);
    idle(2);
    chk(irq == 1'b0, "R5", "irq gated off", {31'd0, irq}, 32'd0);
    wr(2'd0, BIT_IEN);
    chk(irq == 1'b1, "R5", "irq after enable", {31'd0, irq}, 32'd1);
    chk(status_word == exp_status(exp_tag, 1, 1'b0), "R5", "status while gated",
        status_word, exp_status(exp_tag, 1, 1'b0));
    ack_ok("R5");

    // R7: arrival while waiting for the acknowledge
    wr(2'd2, {16'd0, 8'd3, 8'd2});
    send(2, 1'b0);
    check_report(2, 1'b0, 0, "R7");
    send(1, 1'b0);
    chk(status_word == exp_status(exp_tag, 2, 1'b0), "R7", "status held",
        status_word, exp_status(exp_tag, 2, 1'b0));
    ack_ok("R7");
    check_report(1, 1'b0, 3, "R7");
    ack_ok("R7");

    // R7: arrival in the report cycle
    wr(2'd2, {16'd0, 8'd4, 8'd3});
    send(4, 1'b0);
    check_report(3, 1'b0, 0, "R7");
    ack_ok("R7");
    check_report(1, 1'b0, 4, "R7");
    ack_ok("R7");

    // R8: saturation
    wr(2'd2, {16'd0, 8'd2, 8'd255});
    run_batch(130, 1'b0, 127, 2, "R8");

    // R9: path reset mid-report, tag kept, events ignored
    wr(2'd2, {16'd0, 8'd5, 8'd1});
    send(1, 1'b0);
    check_report(1, 1'b0, 0, "R9");
    wr(2'd0, BIT_RST);
    idle(1);
    chk(irq == 1'b0, "R9", "irq under path reset", {31'd0, irq}, 32'd0);
    send(2, 1'b0);
    wr(2'd1, BIT_RST);
    ack_ok("R9");
    idle(2);
    chk(irq == 1'b0, "R9", "no report from ignored events", {31'd0, irq}, 32'd0);
    run_batch(1, 1'b0, 1, 0, "R9");

    // R6: tag wrap from 15 to 0
    for (int k = 0; k < 20 && exp_tag != 4'd0; k++) begin
      run_batch(1, 1'b0, 1, 0, "R6");
    end
    chk(exp_tag == 4'd0, "R6", "tag wrapped", {28'd0, exp_tag}, 32'd0);
    run_batch(1, 1'b0, 1, 0, "R6");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule